// File: doc/BRIEF.md
# Integer ALU with Barrel Shifter

This block is the purely combinational execution unit of a small load/store processor. It takes two 16-bit operands, a 4-bit shift amount and a 5-bit operation code, and in the same cycle returns a 16-bit result together with two comparison flags. The operations are:

- add, subtract, negate and increment;
- the five bitwise functions AND, OR, XOR, NAND and NOR;
- a byte-by-byte multiply;
- a divide that returns quotient and remainder packed into one word;
- rotate-left and three shift kinds, all taken from a staged barrel shifter.

The flags always describe the difference A−B, whatever the selected operation. The branch unit uses them directly: zero means the operands are equal, and negative means the less-than branch is taken. Register file access, immediate extension and branch target arithmetic happen elsewhere.

Top module: `rx_alu`

## Requirements
- R1: Code 0 returns A+B and code 1 returns A−B, both modulo 2^16.
- R2: Codes 2, 3, 4, 5 and 6 return A&B, A|B, A^B, ~(A&B) and ~(A|B) respectively.
- R3: Code 7 returns −A (two's complement) and code 8 returns A+1, both modulo 2^16.
- R4: Code 9 returns the 16-bit product of A[7:0] and B[7:0]; the upper operand bytes have no effect.
- R5: Code 10 with B nonzero returns the low byte of A/B (unsigned) in bits [15:8] and the low byte of A mod B in bits [7:0].
- R6: Code 10 with B equal to zero returns 16'hFFFF.
- R7: The shift codes act on A, moving it by the shift amount:
  - code 11 rotates left;
  - code 12 shifts left and fills with zeros;
  - code 13 shifts right and fills with zeros;
  - code 14 shifts right and fills with copies of A[15].
- R8: With a shift amount of 0, codes 11–14 return A unchanged.
- R9: The zero flag is 1 exactly when the 16-bit A−B is zero, for every operation code.
- R10: The negative flag equals bit 15 of the 16-bit A−B, for every operation code.
- R11: Codes 15 to 31 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand; the shifter source |
| b_i | input | 16 | Second operand |
| shamt_i | input | 4 | Shift or rotate distance |
| op_i | input | 5 | Operation code |
| result_o | output | 16 | Result of the selected operation |
| zero_o | output | 1 | A−B equals zero |
| neg_o | output | 1 | Sign bit of A−B |

## Verification
Random operands over every operation code expose a wrong operation decode or a wrong datapath, because the bit patterns are dense. Directed vectors target the corners that random operands seldom reach:

- equal operands, which separate the zero flag from the negative flag;
- operands whose A−B overflows, which separate a raw sign bit from a signed comparison;
- dividers of zero and one, and a dividend smaller than the divider;
- non-zero upper bytes on the multiplier inputs, which must not affect the product;
- a negative A under the arithmetic right shift, which separates it from the logical one;
- shift amounts of 0 and 15, the two ends of the barrel shifter.

// File: rtl/rx_alu.sv
module rx_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  input  logic [$clog2(W)-1:0] shamt_i,
  input  logic [4:0]           op_i,
  output logic [W-1:0]         result_o,
  output logic                 zero_o,
  output logic                 neg_o
);
  localparam int SW = $clog2(W);
  localparam int H  = W / 2;

  localparam logic [4:0] OP_ADD = 5'd0,  OP_SUB = 5'd1,  OP_AND = 5'd2,  OP_OR  = 5'd3;
  localparam logic [4:0] OP_XOR = 5'd4,  OP_NAND = 5'd5, OP_NOR = 5'd6,  OP_NEG = 5'd7;
  localparam logic [4:0] OP_INC = 5'd8,  OP_MUL = 5'd9,  OP_DIV = 5'd10, OP_ROL = 5'd11;
  localparam logic [4:0] OP_SLL = 5'd12, OP_SRL = 5'd13, OP_SRA = 5'd14;

  logic [W-1:0] diff, quot, rem, prod, shifted, res;
  logic [SW:0][W-1:0] stg;

  assign diff = a_i - b_i;
  assign quot = a_i / b_i;
  assign rem  = a_i % b_i;
  assign prod = W'(a_i[H-1:0]) * W'(b_i[H-1:0]);

  // shift mode from op_i[1:0]: 11 rol, 00 sll, 01 srl, 10 sra
  assign stg[0] = a_i;
  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int D = 1 << k;
    logic [W-1:0] moved;
    always_comb begin
      case (op_i[1:0])
        2'b11:   moved = {stg[k][W-1-D:0], stg[k][W-1:W-D]};
        2'b00:   moved = {stg[k][W-1-D:0], {D{1'b0}}};
        2'b01:   moved = {{D{1'b0}}, stg[k][W-1:D]};
        default: moved = {{D{stg[k][W-1]}}, stg[k][W-1:D]};
      endcase
    end
    assign stg[k+1] = shamt_i[k] ? moved : stg[k];
  end
  assign shifted = stg[SW];

  always_comb begin
    case (op_i)
      OP_ADD:  res = a_i + b_i;
      OP_SUB:  res = diff;
      OP_AND:  res = a_i & b_i;
      OP_OR:   res = a_i | b_i;
      OP_XOR:  res = a_i ^ b_i;
      OP_NAND: res = ~(a_i & b_i);
      OP_NOR:  res = ~(a_i | b_i);
      OP_NEG:  res = W'(0) - a_i;
      OP_INC:  res = a_i + W'(1);
      OP_MUL:  res = prod;
      OP_DIV:  res = (b_i == '0) ? '1 : {quot[H-1:0], rem[H-1:0]};
      OP_ROL, OP_SLL, OP_SRL, OP_SRA: res = shifted;
      default: res = '0;
    endcase
  end

  assign result_o = res;
  assign zero_o   = (diff == '0);
  assign neg_o    = diff[W-1];

  always_comb begin
    if (op_i == OP_SUB)
      AST_SUB_INVERSE: assert (res + b_i == a_i);                        // R1
    if (op_i == OP_INC)
      AST_INC_STEP: assert (res - a_i == W'(1));                         // R3
    if (op_i == OP_DIV && b_i == '0)
      AST_DIV_ZERO_ONES: assert (result_o == '1);                        // R6
    if (op_i == OP_ROL)
      AST_ROT_KEEPS_ONES: assert ($countones(result_o) == $countones(a_i)); // R7
    if (op_i >= OP_ROL && op_i <= OP_SRA && shamt_i == '0)
      AST_SHIFT_NONE: assert (result_o == a_i);                          // R8
    AST_ZERO_EQUAL: assert (zero_o == (a_i == b_i));                     // R9
    if (op_i > OP_SRA)
      AST_UNUSED_ZERO: assert (result_o == '0);                          // R11
  end
endmodule

// File: tb/rx_alu_test.sv
module rx_alu_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] a, b;
  logic [3:0]  sh;
  logic [4:0]  op;
  logic [15:0] res;
  logic        zf, nf;
  int checks = 0, fails = 0;
  bit done = 0;

  rx_alu uut (.a_i(a), .b_i(b), .shamt_i(sh), .op_i(op),
              .result_o(res), .zero_o(zf), .neg_o(nf));

  function automatic logic [15:0] model(input logic [4:0] o, input logic [15:0] x,
                                        input logic [15:0] y, input logic [3:0] s);
    logic [31:0] dbl;
    logic [15:0] r;
    case (o)
      5'd0:  r = x + y;
      5'd1:  r = x - y;
      5'd2:  r = x & y;
      5'd3:  r = x | y;
      5'd4:  r = x ^ y;
      5'd5:  r = ~(x & y);
      5'd6:  r = ~(x | y);
      5'd7:  r = -x;
      5'd8:  r = x + 16'd1;
      5'd9:  r = {8'd0, x[7:0]} * {8'd0, y[7:0]};
      5'd10: if (y == 0) r = 16'hFFFF;
             else begin
               logic [15:0] q, m;
               q = x / y; m = x % y;
               r = {q[7:0], m[7:0]};
             end
      5'd11: begin dbl = {x, x} << s; r = dbl[31:16]; end
      5'd12: r = x << s;
      5'd13: r = x >> s;
      5'd14: r = 16'($signed(x) >>> s);
      default: r = 16'd0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [4:0] o);
    if (o <= 5'd1) return "R1";
    if (o <= 5'd6) return "R2";
    if (o <= 5'd8) return "R3";
    if (o == 5'd9) return "R4";
    if (o == 5'd10) return "R5";
    if (o <= 5'd14) return "R7";
    return "R11";
  endfunction

  task automatic apply(input logic [4:0] o, input logic [15:0] x,
                       input logic [15:0] y, input logic [3:0] s, input string tag);
    logic [15:0] e, d;
    @(negedge clk);
    op = o; a = x; b = y; sh = s;
    #2;
    e = model(o, x, y, s);
    d = x - y;
    checks++;
    if (res !== e) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d result actual=%h expected=%h", tag, o, x, y, s, res, e);
    end
    checks++;
    if (zf !== (d == 0)) begin
      fails++;
      $display("FAIL R9 zero flag a=%h b=%h actual=%b expected=%b", x, y, zf, d == 0);
    end
    checks++;
    if (nf !== d[15]) begin
      fails++;
      $display("FAIL R10 neg flag a=%h b=%h actual=%b expected=%b", x, y, nf, d[15]);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    a = 0; b = 0; sh = 0; op = 0;
    // directed corners
    apply(5'd0, 16'hFFFF, 16'h0001, 4'd0, "R1");
    apply(5'd1, 16'h0000, 16'h0001, 4'd0, "R1");
    apply(5'd1, 16'h8000, 16'h0001, 4'd0, "R10");  // overflowing A-B
    apply(5'd1, 16'h1234, 16'h1234, 4'd0, "R9");
    apply(5'd5, 16'hF0F0, 16'hFF00, 4'd0, "R2");
    apply(5'd6, 16'hF0F0, 16'h0F00, 4'd0, "R2");
    apply(5'd7, 16'h8000, 16'h0000, 4'd0, "R3");
    apply(5'd8, 16'hFFFF, 16'h0000, 4'd0, "R3");
    apply(5'd9, 16'hABFF, 16'hCDFF, 4'd0, "R4");   // upper bytes ignored
    apply(5'd10, 16'd1000, 16'd7, 4'd0, "R5");
    apply(5'd10, 16'd5, 16'd9, 4'd0, "R5");
    apply(5'd10, 16'h1234, 16'd1, 4'd0, "R5");
    apply(5'd10, 16'h1234, 16'd0, 4'd0, "R6");
    apply(5'd11, 16'h8001, 16'd0, 4'd15, "R7");
    apply(5'd14, 16'h8000, 16'd0, 4'd15, "R7");
    apply(5'd13, 16'h8000, 16'd0, 4'd15, "R7");
    apply(5'd12, 16'h0001, 16'd0, 4'd15, "R7");
    for (int o = 11; o <= 14; o++) apply(5'(o), 16'hA5C3, 16'd0, 4'd0, "R8");
    for (int o = 15; o <= 31; o++) apply(5'(o), 16'hFFFF, 16'h1234, 4'd7, "R11");
    // random sweep
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] o;
      o = 5'($urandom_range(0, 31));
      apply(o, 16'($urandom), 16'($urandom), 4'($urandom), tag_of(o));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule